// File: doc/BRIEF.md
# Coherent Sampling Beat Digitizer

This block turns two free-running ring oscillators into random bits by coherent sampling. The signal oscillator is sampled by a flip-flop clocked directly by the reference oscillator, with no divider. Because the two frequencies are close, the sampled stream is a slow beat waveform. The exact length of each beat period depends on the jitter that has built up between the two oscillators.

A counter in the reference domain measures every beat period in reference cycles. When a period closes, the least significant bit of its length becomes the random bit. The full length is exported as well, so software can check that the frequency ratio stays in range. A total-failure alarm trips when the beat stops toggling. The alarm stays set until the block is disabled. The bit, its count and the alarm cross into the system clock domain. A single-cycle valid strobe qualifies each bit.

Top module: `coso_beat_digitizer`

## Requirements
- R1: While `sys_rst_n` is low, `rnd_valid`, `alarm`, `rnd_bit` and `beat_count` are all 0.
- R2: `osc_sig` is sampled on rising edges of `osc_ref` through `SYNC_STAGES` flops. A beat period runs from one rising edge of the sampled beat to the next.
- R3: For each completed period, `beat_count` shows the number of `osc_ref` rising edges between the two beat rising edges. It updates in the same cycle as `rnd_valid` and holds its value otherwise.
- R4: `rnd_bit` equals bit 0 of that period length (odd length gives 1).
- R5: Each completed period yields exactly one `rnd_valid` pulse of one `sys_clk` cycle. The first beat rising edge after enable only starts measurement and yields no pulse.
- R6: With a nonzero `timeout`, `alarm` rises once the running count reaches `timeout` without a beat rising edge. It stays low while periods are shorter than `timeout`.
- R7: With `timeout` equal to 0, only saturation raises the alarm. The counter stops at 2^CNT_W-1 (0xFFFF by default), which raises `alarm`. A period that long is reported as 0xFFFF.
- R8: Once set, `alarm` stays high while `enable` stays high, even if the beat resumes.
- R9: With `enable` low, `alarm` clears and no `rnd_valid` pulse is produced. After re-enable, the first beat rising edge only starts measurement again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset for both domains |
| enable | input | 1 | Run control. Low clears the alarm and stops measurement |
| timeout | input | CNT_W | Alarm limit in reference cycles. 0 disables the limit. Change only while disabled |
| osc_ref | input | 1 | Reference oscillator, used as the sampling clock |
| osc_sig | input | 1 | Signal oscillator being sampled |
| rnd_bit | output | 1 | Random bit, qualified by `rnd_valid` |
| rnd_valid | output | 1 | One-cycle strobe per completed beat period |
| beat_count | output | CNT_W | Length of the last completed beat period |
| alarm | output | 1 | Total-failure alarm, sticky while enabled |

## Verification
A wrong toggle or latch in the reference domain shows at the ports as a missing or extra `rnd_valid` pulse within a few system cycles after the next beat edge. A bad restart value of the counter shows as every reported period being off by a constant. A wrong compare or stuck alarm flop appears as `alarm` rising too early, too late, or never clearing. A fault in saturation shows only after a period longer than 65535 reference cycles. The bench therefore holds the beat still for that long once.

// File: rtl/coso_pkg.sv
package coso_pkg;
   // measurement phase of the reference-domain counter
   typedef enum logic {
      PH_ARM = 1'b0,   // waiting for the first beat edge after enable
      PH_RUN = 1'b1    // a period is being measured
   } coso_phase_e;
endpackage

// File: rtl/coso_sync.sv
module coso_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("coso_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/coso_period_counter.sv
module coso_period_counter
   import coso_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             en,
   input  logic             beat,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] run_cnt,
   output logic             beat_rise,
   output logic [CNT_W-1:0] lat_cnt,
   output logic             lat_tgl,
   output logic             alarm
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 4) begin : g_bad
         $error("coso_period_counter needs CNT_W of at least 4");
      end
   endgenerate

   logic        beat_d;
   coso_phase_e phase;
   logic        trip;

   assign beat_rise = beat & ~beat_d;
   assign trip      = (run_cnt == CNT_MAX) ||
                      ((limit != '0) && (run_cnt >= limit));

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) beat_d <= 1'b0;
      else        beat_d <= beat;
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         phase   <= PH_ARM;
         lat_cnt <= '0;
         lat_tgl <= 1'b0;
         alarm   <= 1'b0;
      end else if (!en) begin
         run_cnt <= '0;
         phase   <= PH_ARM;
         alarm   <= 1'b0;
      end else begin
         if (beat_rise) begin
            run_cnt <= CNT_ONE;
            phase   <= PH_RUN;
            if (phase == PH_RUN) begin
               lat_cnt <= run_cnt;
               lat_tgl <= ~lat_tgl;
            end
         end else if (run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + CNT_ONE;
         end
         if (trip) alarm <= 1'b1;
      end
   end
endmodule

// File: rtl/coso_xfer.sv
module coso_xfer #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic             lat_tgl,
   input  logic [CNT_W-1:0] lat_cnt,
   output logic             rnd_bit,
   output logic             rnd_valid,
   output logic [CNT_W-1:0] beat_count
);
   logic tgl_s;
   logic tgl_d;

   coso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgl_sync (
      .clk(sys_clk), .rst_n(rst_n), .d(lat_tgl), .q(tgl_s)
   );

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_d      <= 1'b0;
         rnd_valid  <= 1'b0;
         rnd_bit    <= 1'b0;
         beat_count <= '0;
      end else begin
         tgl_d     <= tgl_s;
         rnd_valid <= tgl_s ^ tgl_d;
         if (tgl_s ^ tgl_d) begin
            beat_count <= lat_cnt;
            rnd_bit    <= lat_cnt[0];
         end
      end
   end
endmodule

// File: rtl/coso_beat_digitizer.sv
module coso_beat_digitizer #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             sys_clk,
   input  logic             sys_rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] timeout,
   input  logic             osc_ref,
   input  logic             osc_sig,
   output logic             rnd_bit,
   output logic             rnd_valid,
   output logic [CNT_W-1:0] beat_count,
   output logic             alarm
);
   logic             en_ref;
   logic             beat_ref;
   logic [CNT_W-1:0] run_cnt;
   logic             beat_rise;
   logic [CNT_W-1:0] lat_cnt;
   logic             lat_tgl;
   logic             alarm_ref;

   // first stage of this chain is the coherent sampling flop
   coso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_beat_sync (
      .clk(osc_ref), .rst_n(sys_rst_n), .d(osc_sig), .q(beat_ref)
   );

   coso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
      .clk(osc_ref), .rst_n(sys_rst_n), .d(enable), .q(en_ref)
   );

   coso_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_ref  (osc_ref),
      .rst_n    (sys_rst_n),
      .en       (en_ref),
      .beat     (beat_ref),
      .limit    (timeout),
      .run_cnt  (run_cnt),
      .beat_rise(beat_rise),
      .lat_cnt  (lat_cnt),
      .lat_tgl  (lat_tgl),
      .alarm    (alarm_ref)
   );

   coso_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .sys_clk   (sys_clk),
      .rst_n     (sys_rst_n),
      .lat_tgl   (lat_tgl),
      .lat_cnt   (lat_cnt),
      .rnd_bit   (rnd_bit),
      .rnd_valid (rnd_valid),
      .beat_count(beat_count)
   );

   coso_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_alarm_sync (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(alarm_ref), .q(alarm)
   );
endmodule

// File: rtl/coso_beat_digitizer_chk.sv
module coso_beat_digitizer_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             sys_clk,
   input logic             sys_rst_n,
   input logic             osc_ref,
   input logic             rnd_valid,
   input logic [CNT_W-1:0] beat_count,
   input logic             en_ref,
   input logic             alarm_ref,
   input logic [CNT_W-1:0] run_cnt,
   input logic             beat_rise
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // R5
   valid_pulse_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      rnd_valid |=> !rnd_valid);

   // R3
   count_nonzero_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      rnd_valid |-> (beat_count != '0));

   // R3
   count_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      !rnd_valid |-> $stable(beat_count));

   // R8
   alarm_sticky_chk: assert property (@(posedge osc_ref) disable iff (!sys_rst_n)
      (alarm_ref && en_ref) |=> alarm_ref);

   // R7
   sat_hold_chk: assert property (@(posedge osc_ref) disable iff (!sys_rst_n)
      (en_ref && (run_cnt == CNT_MAX) && !beat_rise) |=> (run_cnt == CNT_MAX));

   // R7
   sat_alarm_chk: assert property (@(posedge osc_ref) disable iff (!sys_rst_n)
      (en_ref && (run_cnt == CNT_MAX)) |=> alarm_ref);

   // R9
   disabled_clear_chk: assert property (@(posedge osc_ref) disable iff (!sys_rst_n)
      !en_ref |=> (!alarm_ref && (run_cnt == '0)));
endmodule

bind coso_beat_digitizer coso_beat_digitizer_chk #(.CNT_W(CNT_W)) u_chk (
   .sys_clk   (sys_clk),
   .sys_rst_n (sys_rst_n),
   .osc_ref   (osc_ref),
   .rnd_valid (rnd_valid),
   .beat_count(beat_count),
   .en_ref    (en_ref),
   .alarm_ref (alarm_ref),
   .run_cnt   (run_cnt),
   .beat_rise (beat_rise)
);

// File: tb/coso_beat_digitizer_bench.sv
module coso_beat_digitizer_bench;
   localparam int CW = 16;
   localparam int NV = 10;
   // stimulus: beat period in reference cycles; expected count equals it, bit is its LSB
   localparam int VEC_P [NV] = '{12, 13, 20, 37, 64, 101, 15, 255, 16, 33};

   logic          sys_clk = 1'b0;
   logic          osc_ref = 1'b0;
   logic          sys_rst_n;
   logic          enable;
   logic [CW-1:0] timeout;
   logic          osc_sig;
   logic          rnd_bit;
   logic          rnd_valid;
   logic [CW-1:0] beat_count;
   logic          alarm;

   int n_chk = 0;
   int n_err = 0;
   int n_cap = 0;
   logic [CW-1:0] cap_cnt [64];
   logic          cap_bit [64];

   always #5 sys_clk = ~sys_clk;
   always #4 osc_ref = ~osc_ref;

   coso_beat_digitizer u_coso_beat_digitizer (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .enable(enable),
      .timeout(timeout), .osc_ref(osc_ref), .osc_sig(osc_sig),
      .rnd_bit(rnd_bit), .rnd_valid(rnd_valid), .beat_count(beat_count),
      .alarm(alarm)
   );

   always @(negedge sys_clk) begin
      if (sys_rst_n === 1'b1 && rnd_valid === 1'b1) begin
         if (n_cap < 64) begin
            cap_cnt[n_cap] = beat_count;
            cap_bit[n_cap] = rnd_bit;
         end
         n_cap = n_cap + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ref_wait(input int k);
      repeat (k) @(negedge osc_ref);
   endtask

   task automatic beat(input int p);
      osc_sig = 1'b1;
      ref_wait(p / 2);
      osc_sig = 1'b0;
      ref_wait(p - p / 2);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge sys_clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      int base;
      sys_rst_n = 1'b0;
      enable    = 1'b0;
      timeout   = 16'd1000;
      osc_sig   = 1'b0;
      repeat (5) @(negedge sys_clk);
      chk("R1 valid", {31'd0, rnd_valid}, 32'd0);
      chk("R1 alarm", {31'd0, alarm}, 32'd0);
      chk("R1 count", {16'd0, beat_count}, 32'd0);
      chk("R1 bit", {31'd0, rnd_bit}, 32'd0);
      sys_rst_n = 1'b1;
      repeat (3) @(negedge sys_clk);

      // vector table: N+1 rising edges give N reports (R2, R5)
      enable = 1'b1;
      ref_wait(10);
      base = n_cap;
      for (int i = 0; i < NV; i++) beat(VEC_P[i]);
      osc_sig = 1'b1;
      ref_wait(40);
      chk("R5 report count", n_cap - base, NV);
      for (int i = 0; i < NV; i++) begin
         chk("R3 period", {16'd0, cap_cnt[base+i]}, VEC_P[i]);
         chk("R4 lsb", {31'd0, cap_bit[base+i]}, VEC_P[i] & 1);
      end
      chk("R6 no false alarm", {31'd0, alarm}, 32'd0);

      // R6 timeout alarm with the beat held high
      ref_wait(460);
      chk("R6 before limit", {31'd0, alarm}, 32'd0);
      ref_wait(600);
      chk("R6 after limit", {31'd0, alarm}, 32'd1);

      // R8 alarm stays set after the beat resumes
      osc_sig = 1'b0;
      beat(30);
      beat(30);
      ref_wait(20);
      chk("R8 sticky", {31'd0, alarm}, 32'd1);

      // R9 disable clears alarm and silences output
      enable = 1'b0;
      repeat (10) @(negedge sys_clk);
      chk("R9 alarm cleared", {31'd0, alarm}, 32'd0);
      base = n_cap;
      beat(20);
      beat(20);
      beat(20);
      osc_sig = 1'b1;
      ref_wait(20);
      chk("R9 no reports disabled", n_cap - base, 0);

      // R9 re-enable: first edge arms only
      osc_sig = 1'b0;
      enable  = 1'b1;
      ref_wait(10);
      base = n_cap;
      beat(30);
      beat(41);
      osc_sig = 1'b1;
      ref_wait(40);
      chk("R9 reports after re-enable", n_cap - base, 2);
      chk("R3 period after re-enable", {16'd0, cap_cnt[base]}, 32'd30);
      chk("R3 second period", {16'd0, cap_cnt[base+1]}, 32'd41);
      chk("R4 odd period", {31'd0, cap_bit[base+1]}, 32'd1);

      // R7 saturation with the limit disabled
      enable = 1'b0;
      ref_wait(10);
      timeout = '0;
      osc_sig = 1'b0;
      enable  = 1'b1;
      ref_wait(10);
      base = n_cap;
      osc_sig = 1'b1;
      ref_wait(2000);
      chk("R7 zero limit no alarm", {31'd0, alarm}, 32'd0);
      ref_wait(64000);
      chk("R7 saturation alarm", {31'd0, alarm}, 32'd1);
      osc_sig = 1'b0;
      ref_wait(4);
      osc_sig = 1'b1;
      ref_wait(40);
      chk("R7 one report", n_cap - base, 1);
      chk("R7 saturated count", {16'd0, cap_cnt[base]}, 32'h0000FFFF);
      chk("R4 saturated lsb", {31'd0, cap_bit[base]}, 32'd1);

      finish_run();
   end
endmodule